// File: doc/BRIEF.md
# Indirect Region Address Generator

This block produces the byte addresses of the elements that an indirect source operand reads. An address array holds byte addresses. A start request carries a base index into that array, a signed byte offset, the three region codes, the element size and the execution size. The block then reads address entries through a registered read port and streams out one element byte address per cycle. Each address comes with a valid flag, a last flag and a per-lane misalignment flag.

Two modes are supported. In per-row mode, each row of the region takes its origin from its own entry of the address array. In shared-origin mode, a single entry plus the offset gives the origin, and the rows are stepped by the vertical stride. A request with an illegal configuration is refused with a one-cycle error pulse and produces no addresses. The data memory that the addresses point into is outside the block.

Top module: `region_addr_gen`

## Requirements
- R1: After reset the block is idle: `busy`, `out_valid`, `ar_en` and `cfg_err` are 0.
- R2: Stride codes map as follows: 0→null, 1→0, 2→1, 3→2, 4→4, 5→8, 6→16, 7→32 elements. The element size is 2^`esz_log2` bytes and the execution size is 2^`exec_log2` elements. The vertical code 0 selects per-row mode. In per-row mode there are exec/width rows. Row i starts at entry[k+i] + offset, with k+i wrapping modulo the array size, and element j of the row is at that start + j × hstride × element size. Addresses come out in row-major order.
- R3: With a width of 1 in per-row mode, one entry is read per element, so 2^`exec_log2` consecutive entries are read.
- R4: Any vertical code from 1 to 7 selects shared-origin mode. Only entry[k] is read, exactly once, and element (i,j) is at entry[k] + offset + (i × vstride + j × hstride) × element size.
- R5: A read of entry k is issued (`ar_en`=1, `ar_idx`=k) in the cycle a legal start is taken. The first address is valid in the next cycle. Addresses then follow in every cycle with no gap, including across rows. `out_last` marks the final one, and `out_valid` drops in the cycle after it.
- R6: The offset is a two's-complement value. Offsets from -512 to 511 inclusive are accepted and applied with their sign.
- R7: An offset outside -512..511 refuses the request: no read is issued, `cfg_err` is 1 for the single cycle after the start, and no address is produced.
- R8: An address with any of its low `esz_log2` bits set raises `out_misalign` on that lane only. The sequence still runs to completion.
- R9: With `is_dst`=1, per-row mode or a horizontal code of 1 (stride 0) refuses the request as in R7. A destination request with a legal shared-origin configuration runs normally.
- R10: The following also refuse the request as in R7: a width code outside 2..6, a horizontal code outside 1..4, a vertical code above 7, `exec_log2` above 5, or a width greater than the execution size.
- R11: A start raised while `busy` is 1 is ignored. The running sequence's addresses are unchanged and no extra read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a new sequence (taken only when idle) |
| is_dst | input | 1 | Request is for a destination operand |
| base_idx | input | IDX_W | Address-array index k |
| imm_off | input | OFF_W | Signed byte offset |
| vs_code | input | 4 | Vertical stride code (0 = per-row mode) |
| w_code | input | 4 | Width code |
| hs_code | input | 4 | Horizontal stride code |
| esz_log2 | input | 2 | log2 of element size in bytes |
| exec_log2 | input | 3 | log2 of execution size |
| busy | output | 1 | Sequence in progress |
| cfg_err | output | 1 | One-cycle pulse after a refused start |
| ar_en | output | 1 | Address-array read enable |
| ar_idx | output | IDX_W | Address-array read index |
| ar_data | input | ADDR_W | Read data, valid the cycle after `ar_en` |
| out_valid | output | 1 | Element address valid |
| out_addr | output | ADDR_W | Element byte address |
| out_last | output | 1 | Final address of the sequence |
| out_misalign | output | 1 | This address is not aligned to the element size |

## Verification
Per-row mode is tried with several region shapes: four rows of four, width one over eight entries, and a zero horizontal stride. These show whether each row truly takes its own entry, and whether row boundaries are crossed without a gap. Shared-origin runs with a vertical stride of 8 and of 0 show whether only one entry is read and whether rows step by stride rather than by fetching. The extreme offsets -512 and 511 separate correct sign handling from truncation, and the out-of-range offsets one step beyond them prove that the range check sits on the exact edges. A planted odd entry shows that misalignment is flagged per lane without cutting the run short, and a start raised mid-run shows that a busy sequence cannot be disturbed.

// File: rtl/region_addr_gen.sv
module region_addr_gen #(
  parameter int ADDR_W        = 32,
  parameter int IDX_W         = 4,
  parameter int OFF_W         = 16,
  parameter int OFF_LO        = -512,
  parameter int OFF_HI        = 511,
  parameter int MAX_EXEC_LOG2 = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_dst,
  input  logic [IDX_W-1:0]  base_idx,
  input  logic [OFF_W-1:0]  imm_off,
  input  logic [3:0]        vs_code,
  input  logic [3:0]        w_code,
  input  logic [3:0]        hs_code,
  input  logic [1:0]        esz_log2,
  input  logic [2:0]        exec_log2,
  output logic              busy,
  output logic              cfg_err,
  output logic              ar_en,
  output logic [IDX_W-1:0]  ar_idx,
  input  logic [ADDR_W-1:0] ar_data,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_last,
  output logic              out_misalign
);
  localparam int CNT_W = MAX_EXEC_LOG2 + 1;

  function automatic logic [5:0] stride_val(input logic [3:0] c);
    if (c < 4'd2) return 6'd0;
    return 6'd1 << (c - 4'd2);
  endfunction

  // request legality
  logic signed [OFF_W-1:0] off_s;
  logic w_ok, hs_ok, vs_ok, ex_ok, fit_ok, off_ok, dst_ok, cfg_ok, accept;
  logic [3:0] wlog;
  logic [CNT_W-1:0] wlast_d, rlast_d;

  assign off_s   = imm_off;
  assign w_ok    = (w_code >= 4'd2) && (w_code <= 4'd6);
  assign hs_ok   = (hs_code >= 4'd1) && (hs_code <= 4'd4);
  assign vs_ok   = (vs_code <= 4'd7);
  assign ex_ok   = (int'(exec_log2) <= MAX_EXEC_LOG2);
  assign wlog    = w_code - 4'd2;
  assign fit_ok  = ({1'b0, wlog} <= {2'b00, exec_log2});
  assign off_ok  = (int'(off_s) >= OFF_LO) && (int'(off_s) <= OFF_HI);
  assign dst_ok  = !is_dst || ((vs_code != 4'd0) && (hs_code != 4'd1));
  assign cfg_ok  = w_ok && hs_ok && vs_ok && ex_ok && fit_ok && off_ok && dst_ok;
  assign accept  = start && !busy;
  assign wlast_d = CNT_W'((32'd1 << wlog) - 32'd1);
  assign rlast_d = CNT_W'((32'd1 << (exec_log2 - wlog[2:0])) - 32'd1);

  // latched request
  logic              multi_q;
  logic [IDX_W-1:0]  k_q;
  logic [ADDR_W-1:0] off_q, hstep_q, vstep_q, rowbase_q;
  logic [CNT_W-1:0]  wlast_q, rlast_q, col_q, row_q;
  logic [2:0]        emask_q;

  // element address path
  logic last_col, last_row, fresh;
  logic [ADDR_W-1:0] row_start;

  assign last_col  = (col_q == wlast_q);
  assign last_row  = (row_q == rlast_q);
  assign fresh     = multi_q ? (col_q == '0) : ((row_q == '0) && (col_q == '0));
  assign row_start = fresh ? (ar_data + off_q)
                   : ((col_q == '0) ? (rowbase_q + vstep_q) : rowbase_q);

  assign out_valid    = busy;
  assign out_addr     = row_start + ADDR_W'(col_q) * hstep_q;
  assign out_last     = busy && last_col && last_row;
  assign out_misalign = busy && (|(out_addr[2:0] & emask_q));

  assign ar_en  = (accept && cfg_ok) || (busy && multi_q && last_col && !last_row);
  assign ar_idx = busy ? (k_q + IDX_W'(row_q) + IDX_W'(1)) : base_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cfg_err   <= 1'b0;
      multi_q   <= 1'b0;
      k_q       <= '0;
      off_q     <= '0;
      hstep_q   <= '0;
      vstep_q   <= '0;
      rowbase_q <= '0;
      wlast_q   <= '0;
      rlast_q   <= '0;
      col_q     <= '0;
      row_q     <= '0;
      emask_q   <= '0;
    end else begin
      cfg_err <= accept && !cfg_ok;
      if (accept && cfg_ok) begin
        busy    <= 1'b1;
        multi_q <= (vs_code == 4'd0);
        k_q     <= base_idx;
        off_q   <= {{(ADDR_W-OFF_W){imm_off[OFF_W-1]}}, imm_off};
        hstep_q <= ADDR_W'(stride_val(hs_code)) << esz_log2;
        vstep_q <= ADDR_W'(stride_val(vs_code)) << esz_log2;
        wlast_q <= wlast_d;
        rlast_q <= rlast_d;
        emask_q <= 3'((4'd1 << esz_log2) - 4'd1);
        col_q   <= '0;
        row_q   <= '0;
      end else if (busy) begin
        if (col_q == '0) rowbase_q <= row_start;
        if (last_col) begin
          col_q <= '0;
          if (last_row) busy <= 1'b0;
          else          row_q <= row_q + 1'b1;
        end else begin
          col_q <= col_q + 1'b1;
        end
      end
    end
  end

  assert_idle_after_reset_R1: assert property (@(posedge clk)
    $fell(rst_n) |=> !busy && !cfg_err);

  assert_first_follows_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ar_en && !busy) |=> out_valid);

  assert_row_fetch_no_bubble_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ar_en && busy) |=> (out_valid && !$stable(row_q)));

  assert_last_ends_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |=> !out_valid);

  assert_single_one_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !multi_q) |-> !ar_en);

  assert_refused_no_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !out_valid);

  assert_byte_never_misaligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && emask_q == 3'd0) |-> !out_misalign);

  assert_busy_start_no_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !multi_q) |-> !ar_en);
endmodule

// File: tb/region_addr_gen_bench.sv
module region_addr_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ENTRIES = 16;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, is_dst = 1'b0;
  logic [3:0] base_idx = '0;
  logic [15:0] imm_off = '0;
  logic [3:0] vs_code = '0, w_code = '0, hs_code = '0;
  logic [1:0] esz_log2 = '0;
  logic [2:0] exec_log2 = '0;
  logic busy, cfg_err, ar_en, out_valid, out_last, out_misalign;
  logic [3:0] ar_idx;
  logic [31:0] ar_data = '0, out_addr;
  logic [31:0] mem [ENTRIES];
  int checks = 0, fails = 0, nreads = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  region_addr_gen u_region_addr_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .is_dst(is_dst), .base_idx(base_idx),
    .imm_off(imm_off), .vs_code(vs_code), .w_code(w_code), .hs_code(hs_code),
    .esz_log2(esz_log2), .exec_log2(exec_log2), .busy(busy), .cfg_err(cfg_err),
    .ar_en(ar_en), .ar_idx(ar_idx), .ar_data(ar_data), .out_valid(out_valid),
    .out_addr(out_addr), .out_last(out_last), .out_misalign(out_misalign));

  always @(posedge clk) begin
    if (ar_en) begin
      ar_data <= mem[ar_idx];
      nreads <= nreads + 1;
    end
  end

  function automatic int cval(input logic [3:0] c);
    return (c < 2) ? 0 : (1 << (c - 2));
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input bit dst, input int k, input int off, input logic [3:0] vs,
                       input logic [3:0] w, input logic [3:0] hs, input logic [1:0] es,
                       input logic [2:0] ex);
    is_dst = dst; base_idx = 4'(k); imm_off = 16'(off);
    vs_code = vs; w_code = w; hs_code = hs; esz_log2 = es; exec_log2 = ex;
  endtask

  task automatic run_ok(input string req, input bit dst, input int k, input int off,
                        input logic [3:0] vs, input logic [3:0] w, input logic [3:0] hs,
                        input logic [1:0] es, input logic [2:0] ex, input bit poke);
    int wv, total, esb, rows;
    logic [31:0] base, e;
    wv = cval(w); total = 1 << ex; esb = 1 << es; rows = total / wv;
    @(negedge clk);
    nreads = 0;
    drive(dst, k, off, vs, w, hs, es, ex);
    start = 1'b1;
    #1;
    chk(ar_en === 1'b1, "R5", "read issued at start", 32'(ar_en), 1);
    chk(ar_idx === 4'(k), "R5", "first read index", 32'(ar_idx), 32'(k));
    @(negedge clk);
    start = 1'b0;
    for (int n = 0; n < total; n++) begin
      int i, j;
      i = n / wv; j = n % wv;
      if (vs == 4'd0) base = mem[(k + i) % ENTRIES];
      else            base = mem[k] + 32'(i * cval(vs) * esb);
      e = base + 32'(off) + 32'(j * cval(hs) * esb);
      chk(out_valid === 1'b1, req, "valid with no gap", 32'(out_valid), 1);
      chk(out_addr === e, req, "element address", out_addr, e);
      chk(out_last === (n == total - 1), req, "last flag", 32'(out_last), 32'(n == total - 1));
      chk(out_misalign === ((e & 32'(esb - 1)) != 0), req, "misalign flag",
          32'(out_misalign), 32'((e & 32'(esb - 1)) != 0));
      if (poke && n == 1) begin
        start = 1'b1; base_idx = 4'(k + 7); imm_off = 16'd4; vs_code = 4'd0;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    chk(out_valid === 1'b0, "R5", "valid drops after last", 32'(out_valid), 0);
    chk(nreads == ((vs == 4'd0) ? rows : 1), (vs == 4'd0) ? req : "R4", "entry read count",
        32'(nreads), 32'((vs == 4'd0) ? rows : 1));
  endtask

  task automatic reject(input string req, input bit dst, input int off, input logic [3:0] vs,
                        input logic [3:0] w, input logic [3:0] hs, input logic [2:0] ex);
    @(negedge clk);
    drive(dst, 1, off, vs, w, hs, 2'd0, ex);
    start = 1'b1;
    #1;
    chk(ar_en === 1'b0, req, "no read on refused start", 32'(ar_en), 0);
    @(negedge clk);
    start = 1'b0;
    chk(cfg_err === 1'b1, req, "error pulse", 32'(cfg_err), 1);
    chk(out_valid === 1'b0 && busy === 1'b0, req, "no sequence", 32'(out_valid), 0);
    @(negedge clk);
    chk(cfg_err === 1'b0, req, "error is one cycle", 32'(cfg_err), 0);
    chk(out_valid === 1'b0, req, "still idle", 32'(out_valid), 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(busy === 1'b0, "R1", "busy after reset", 32'(busy), 0);
    chk(out_valid === 1'b0, "R1", "valid after reset", 32'(out_valid), 0);
    chk(ar_en === 1'b0, "R1", "read enable after reset", 32'(ar_en), 0);
    chk(cfg_err === 1'b0, "R1", "error after reset", 32'(cfg_err), 0);
  endtask

  task automatic t_per_row;
    run_ok("R2", 1'b0, 0, 8, 4'd0, 4'd4, 4'd2, 2'd2, 3'd4, 1'b0);
    run_ok("R2", 1'b0, 12, 0, 4'd0, 4'd3, 4'd1, 2'd3, 3'd2, 1'b0);
  endtask

  task automatic t_width_one;
    run_ok("R3", 1'b0, 8, -3, 4'd0, 4'd2, 4'd3, 2'd0, 3'd3, 1'b0);
  endtask

  task automatic t_shared;
    run_ok("R4", 1'b0, 3, 16, 4'd5, 4'd4, 4'd2, 2'd1, 3'd3, 1'b0);
    run_ok("R4", 1'b0, 2, 0, 4'd1, 4'd3, 4'd4, 2'd0, 3'd2, 1'b0);
  endtask

  task automatic t_offsets;
    run_ok("R6", 1'b0, 6, -512, 4'd0, 4'd5, 4'd2, 2'd0, 3'd4, 1'b0);
    run_ok("R6", 1'b0, 9, 511, 4'd2, 4'd3, 4'd2, 2'd0, 3'd2, 1'b0);
    reject("R7", 1'b0, 512, 4'd0, 4'd3, 4'd2, 3'd2);
    reject("R7", 1'b0, -513, 4'd0, 4'd3, 4'd2, 3'd2);
  endtask

  task automatic t_misalign;
    run_ok("R8", 1'b0, 4, 0, 4'd0, 4'd3, 4'd2, 2'd2, 3'd2, 1'b0);
  endtask

  task automatic t_dest;
    reject("R9", 1'b1, 0, 4'd0, 4'd3, 4'd2, 3'd2);
    reject("R9", 1'b1, 0, 4'd5, 4'd3, 4'd1, 3'd2);
    run_ok("R9", 1'b1, 1, 4, 4'd5, 4'd3, 4'd2, 2'd1, 3'd2, 1'b0);
  endtask

  task automatic t_illegal;
    reject("R10", 1'b0, 0, 4'd0, 4'd7, 4'd2, 3'd5);
    reject("R10", 1'b0, 0, 4'd0, 4'd3, 4'd5, 3'd2);
    reject("R10", 1'b0, 0, 4'd8, 4'd3, 4'd2, 3'd2);
    reject("R10", 1'b0, 0, 4'd0, 4'd5, 4'd2, 3'd2);
    reject("R10", 1'b0, 0, 4'd0, 4'd2, 4'd2, 3'd6);
  endtask

  task automatic t_busy_start;
    run_ok("R11", 1'b0, 0, 0, 4'd5, 4'd3, 4'd2, 2'd2, 3'd3, 1'b1);
    run_ok("R11", 1'b0, 10, 0, 4'd0, 4'd3, 4'd2, 2'd2, 3'd3, 1'b1);
  endtask

  initial begin
    for (int i = 0; i < ENTRIES; i++) mem[i] = 32'h1000 + 32'(i) * 32'h100;
    mem[5] = 32'h2002;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_per_row();
    t_width_one();
    t_shared();
    t_offsets();
    t_misalign();
    t_dest();
    t_illegal();
    t_busy_start();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule